// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes a run of bytes into a byte-wide parallel EPROM. A host gives it a start address and a byte count, then supplies the bytes through a valid/ready stream. The sequencer first raises the programming-voltage request and waits for it to settle. It then handles each address in turn.

For every byte it first reads the cell in verify mode. A byte that already matches gets no pulse. A byte that would need a 0 turned back into a 1 is refused at once. Any other byte gets fixed-width program pulses, each followed by a recovery cycle and a verify read, until the read-back matches. No extra pulse is applied after a match. The run stops with a failure and the offending address when a byte cannot be programmed or when it uses up its retry budget.

Between bytes and at the end, the device is held in program inhibit. The voltage request is dropped only after inhibit has been entered.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset and whenever idle, the block holds dev_ce_n=1, dev_oe_n=1, dev_pgm_n=1, dev_vpp_req=0, dev_dq_oe=0, busy=0, done=0 and fail=0 (the last two until the first run ends).
- R2: A run with a nonzero length raises dev_vpp_req. The first program pulse starts only after dev_vpp_req has been high for at least SETTLE_CYC cycles.
- R3: During a program pulse the pins are dev_ce_n=0, dev_oe_n=1, dev_pgm_n=0, dev_vpp_req=1 and dev_dq_oe=1, with the requested byte on dev_dq_out. dev_pgm_n stays low for exactly PULSE_CYC cycles.
- R4: During a verify read the pins are dev_ce_n=0, dev_oe_n=0, dev_pgm_n=1 and dev_dq_oe=0. At least one cycle with dev_pgm_n=1 and dev_oe_n=1 separates a pulse from the following read. dev_oe_n stays low for exactly OE_CYC cycles, and dev_dq_in is sampled on the last of them.
- R5: A programmable byte gets exactly as many pulses as it takes for its read-back to match the requested value. No pulse is applied after the match.
- R6: Each byte is read once before any pulse. A byte whose read-back already matches, such as 0xFF on an erased cell, gets zero pulses.
- R7: If the requested byte has a 1 in a bit position where the read-back shows 0, the run ends with fail=1 and fail_addr set to that address. No pulse is applied to that byte, and later bytes are not touched.
- R8: A byte still unmatched after MAX_PULSES pulses ends the run with fail=1 and fail_addr set to its address. A byte that matches on exactly the MAX_PULSES-th pulse passes.
- R9: dev_ce_n goes high for at least one cycle whenever dev_addr changes between bytes. dev_vpp_req falls only in a cycle after dev_ce_n was already high.
- R10: Bytes go to consecutive addresses starting at base_addr, and the run ends with done=1. A length of 0 sets done=1 without raising dev_vpp_req.
- R11: done and fail are never high together, and neither is high while busy. Both are cleared when a new run starts. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| base_addr | input | AW | First device address of the run |
| length | input | AW+1 | Number of bytes to program |
| wr_data | input | 8 | Byte stream data |
| wr_valid | input | 1 | Byte stream valid |
| wr_ready | output | 1 | Sequencer takes the next byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished with every byte verified |
| fail | output | 1 | Last run stopped on a byte that could not be programmed |
| fail_addr | output | AW | Address of the failing byte |
| dev_addr | output | AW | Device address lines |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_pgm_n | output | 1 | Device program strobe, active low |
| dev_vpp_req | output | 1 | Request for programming voltage |
| dev_dq_out | output | 8 | Data driven to the device during pulses |
| dev_dq_oe | output | 1 | Drive enable for dev_dq_out |
| dev_dq_in | input | 8 | Data read from the device |

## Verification
The bench builds the block with AW=6, PULSE_CYC=5, SETTLE_CYC=7, OE_CYC=2 and MAX_PULSES=4. The short timings keep every pulse, recovery and verify window to a handful of cycles, so the pin monitors see hundreds of mode transitions within a short run. With a retry limit of four, a modelled byte needing exactly four pulses (which must pass) and one needing five (which must fail after four) are both reachable. The 64-byte device model places each scenario at its own addresses and watches neighbours for stray writes.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FETCH,
        ST_RECOV,
        ST_VERIFY,
        ST_PULSE,
        ST_END
    } burn_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic vpp;
        logic dq_oe;
    } pin_ctl_t;

endpackage

// File: rtl/prom_burn_timer.sv
module prom_burn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/prom_burn_cmp.sv
module prom_burn_cmp (
    input  logic [7:0] want,
    input  logic [7:0] got,
    output logic       match,
    output logic       unreach
);
    // Programming only clears bits: a 1 wanted over a 0 read is lost.
    assign match   = (want == got);
    assign unreach = |(want & ~got);
endmodule

// File: rtl/prom_burn_pins.sv
module prom_burn_pins
    import prom_burn_pkg::*;
(
    input  burn_state_e st,
    output pin_ctl_t    ctl
);
    always_comb begin
        ctl = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, vpp: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_IDLE:   ctl.vpp = 1'b0;
            ST_SETTLE,
            ST_FETCH,
            ST_END:    ctl.ce_n = 1'b1;
            ST_RECOV:  ctl.ce_n = 1'b0;
            ST_VERIFY: begin
                ctl.ce_n = 1'b0;
                ctl.oe_n = 1'b0;
            end
            ST_PULSE:  begin
                ctl.ce_n  = 1'b0;
                ctl.pgm_n = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            default:   ctl.vpp = 1'b0;
        endcase
    end
endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
    import prom_burn_pkg::*;
#(
    parameter int AW         = 17,
    parameter int PULSE_CYC  = 10000,
    parameter int SETTLE_CYC = 200,
    parameter int OE_CYC     = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   length,
    input  logic [7:0]    wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [AW-1:0] dev_addr,
    output logic          dev_ce_n,
    output logic          dev_oe_n,
    output logic          dev_pgm_n,
    output logic          dev_vpp_req,
    output logic [7:0]    dev_dq_out,
    output logic          dev_dq_oe,
    input  logic [7:0]    dev_dq_in
);
    localparam int LW   = AW + 1;
    localparam int TMAX = (PULSE_CYC > SETTLE_CYC)
                        ? ((PULSE_CYC > OE_CYC) ? PULSE_CYC : OE_CYC)
                        : ((SETTLE_CYC > OE_CYC) ? SETTLE_CYC : OE_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int NW   = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        burn_state_e   st;
        logic [AW-1:0] addr;
        logic [LW-1:0] left;
        logic [7:0]    want;
        logic [NW-1:0] npulse;
        logic          bad;
        logic          done;
        logic          fail;
        logic [AW-1:0] fail_addr;
    } seq_t;

    seq_t          s_d, s_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          rb_match;
    logic          rb_unreach;
    pin_ctl_t      pins;

    prom_burn_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    prom_burn_cmp u_cmp (
        .want    (s_q.want),
        .got     (dev_dq_in),
        .match   (rb_match),
        .unreach (rb_unreach)
    );

    prom_burn_pins u_pins (
        .st  (s_q.st),
        .ctl (pins)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        wr_ready = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.done = 1'b0;
                    s_d.fail = 1'b0;
                    if (length == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.addr = base_addr;
                        s_d.left = length;
                        s_d.st   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SETTLE_CYC - 1);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    s_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    s_d.want   = wr_data;
                    s_d.npulse = '0;
                    s_d.st     = ST_RECOV;
                end
            end
            ST_RECOV: begin
                s_d.st   = ST_VERIFY;
                tmr_load = 1'b1;
                tmr_val  = TW'(OE_CYC - 1);
            end
            ST_VERIFY: begin
                if (tmr_zero) begin
                    if (rb_match) begin
                        s_d.addr = s_q.addr + AW'(1);
                        s_d.left = s_q.left - LW'(1);
                        s_d.st   = (s_q.left == LW'(1)) ? ST_END : ST_FETCH;
                    end else if (rb_unreach || (s_q.npulse == NW'(MAX_PULSES))) begin
                        s_d.bad       = 1'b1;
                        s_d.fail_addr = s_q.addr;
                        s_d.st        = ST_END;
                    end else begin
                        s_d.npulse = s_q.npulse + NW'(1);
                        s_d.st     = ST_PULSE;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(PULSE_CYC - 1);
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    s_d.st = ST_RECOV;
                end
            end
            ST_END: begin
                s_d.st   = ST_IDLE;
                s_d.fail = s_q.bad;
                s_d.done = ~s_q.bad;
                s_d.bad  = 1'b0;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, left: '0, want: '0, npulse: '0,
                     bad: 1'b0, done: 1'b0, fail: 1'b0, fail_addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign done        = s_q.done;
    assign fail        = s_q.fail;
    assign fail_addr   = s_q.fail_addr;
    assign dev_addr    = s_q.addr;
    assign dev_dq_out  = s_q.want;
    assign dev_ce_n    = pins.ce_n;
    assign dev_oe_n    = pins.oe_n;
    assign dev_pgm_n   = pins.pgm_n;
    assign dev_vpp_req = pins.vpp;
    assign dev_dq_oe   = pins.dq_oe;
endmodule

// File: rtl/prom_burn_seq_chk.sv
module prom_burn_seq_chk #(
    parameter int PULSE_CYC  = 10000,
    parameter int SETTLE_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic fail,
    input logic dev_ce_n,
    input logic dev_oe_n,
    input logic dev_pgm_n,
    input logic dev_vpp_req,
    input logic dev_dq_oe
);
    localparam int LIM = ((PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC) + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] vpp_cnt;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpp_cnt <= '0;
            low_cnt <= '0;
        end else begin
            if (!dev_vpp_req) begin
                vpp_cnt <= '0;
            end else if (vpp_cnt < CW'(SETTLE_CYC)) begin
                vpp_cnt <= vpp_cnt + CW'(1);
            end
            if (dev_pgm_n) begin
                low_cnt <= '0;
            end else if (low_cnt < CW'(LIM)) begin
                low_cnt <= low_cnt + CW'(1);
            end
        end
    end

    // R3
    pgm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_pgm_n |-> (!dev_ce_n && dev_oe_n && dev_vpp_req && dev_dq_oe));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_pgm_n) |-> (low_cnt == CW'(PULSE_CYC)));

    // R4
    verify_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> (!dev_ce_n && dev_pgm_n && !dev_dq_oe));

    // R4
    recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_oe_n) |-> ($past(dev_pgm_n) && !$past(dev_dq_oe)));

    // R2
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_pgm_n) |-> (vpp_cnt >= CW'(SETTLE_CYC)));

    // R9
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ce_n |-> (dev_oe_n && dev_pgm_n && !dev_dq_oe));

    // R9
    vpp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_vpp_req) |-> $past(dev_ce_n));

    // R11
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R11
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !fail));
endmodule

bind prom_burn_seq prom_burn_seq_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .dev_ce_n    (dev_ce_n),
    .dev_oe_n    (dev_oe_n),
    .dev_pgm_n   (dev_pgm_n),
    .dev_vpp_req (dev_vpp_req),
    .dev_dq_oe   (dev_dq_oe)
);

// File: tb/prom_burn_seq_tb.sv
module prom_burn_seq_tb;
    localparam int AW    = 6;
    localparam int NB    = 1 << AW;
    localparam int PULSE = 5;
    localparam int SETTL = 7;
    localparam int OEC   = 2;
    localparam int MAXP  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   length = '0;
    logic [7:0]    wr_data;
    logic          wr_valid = 1'b0;
    logic          wr_ready, busy, done, fail;
    logic [AW-1:0] fail_addr, dev_addr;
    logic          dev_ce_n, dev_oe_n, dev_pgm_n, dev_vpp_req, dev_dq_oe;
    logic [7:0]    dev_dq_out, dev_dq_in;

    always #2 clk = ~clk;

    prom_burn_seq #(
        .AW(AW), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTL), .OE_CYC(OEC), .MAX_PULSES(MAXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .length(length),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy),
        .done(done), .fail(fail), .fail_addr(fail_addr), .dev_addr(dev_addr),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n),
        .dev_vpp_req(dev_vpp_req), .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe),
        .dev_dq_in(dev_dq_in)
    );

    int checks = 0;
    int errors = 0;

    // Stream source
    logic [7:0] src [NB];
    logic [6:0] idx;
    logic       idx_clr = 1'b0;
    always @(posedge clk) begin
        if (idx_clr) idx <= '0;
        else if (wr_valid && wr_ready) idx <= idx + 7'd1;
    end
    assign wr_data = src[idx[AW-1:0]];

    // Behavioural device: a cell accepts its data only after need[] pulses.
    logic [7:0] init_mem [NB];
    int         need [NB];
    logic [7:0] mem [NB];
    int         got [NB];
    logic       load_req = 1'b0;
    int bad_pw = 0, bad_settle = 0, bad_oe = 0, bad_rec = 0;
    int bad_bus = 0, bad_inh = 0, bad_vpp = 0;
    int pw = 0, ow = 0, vpp_cnt = 0;
    logic [7:0]    pdata = '0;
    logic [AW-1:0] paddr = '0, prev_addr = '0;
    logic prev_pgm = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_vpp = 1'b0;

    assign dev_dq_in = (!dev_ce_n && !dev_oe_n) ? mem[dev_addr] : 8'h00;

    always @(negedge clk) begin
        if (load_req) begin
            for (int a = 0; a < NB; a++) begin
                mem[a] = init_mem[a];
                got[a] = 0;
            end
        end else begin
            if (!dev_pgm_n) begin
                if (prev_pgm && vpp_cnt < SETTL) bad_settle++;
                pw++;
                pdata = dev_dq_out;
                paddr = dev_addr;
            end else if (!prev_pgm) begin
                if (pw != PULSE) bad_pw++;
                got[paddr]++;
                if (got[paddr] >= need[paddr]) mem[paddr] = mem[paddr] & pdata;
                pw = 0;
            end
            if (!dev_oe_n) begin
                if (prev_oe && !prev_pgm) bad_rec++;
                ow++;
            end else if (!prev_oe) begin
                if (ow != OEC) bad_oe++;
                ow = 0;
            end
            if (dev_dq_oe && !dev_oe_n) bad_bus++;
            if (!dev_ce_n && !prev_ce && dev_addr != prev_addr) bad_inh++;
            if (prev_vpp && !dev_vpp_req && !prev_ce) bad_vpp++;
            if (!dev_vpp_req && !dev_ce_n) bad_vpp++;
            vpp_cnt = dev_vpp_req ? vpp_cnt + 1 : 0;
        end
        prev_pgm  = dev_pgm_n;
        prev_oe   = dev_oe_n;
        prev_ce   = dev_ce_n;
        prev_vpp  = dev_vpp_req;
        prev_addr = dev_addr;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int a = 0; a < NB; a++) begin
            init_mem[a] = 8'hFF;
            need[a]     = 1;
            src[a]      = 8'hFF;
        end
    endtask

    task automatic model_load();
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        load_req = 1'b0;
    endtask

    // Starts a run and waits for done or fail; inj_at > 0 fires a second start mid-run.
    task automatic run(input int base, input int len, input int inj_at,
                       output int cyc, output bit saw_vpp, output bit clr_ok);
        saw_vpp = 1'b0;
        @(negedge clk);
        idx_clr = 1'b1; base_addr = AW'(base); length = (AW+1)'(len);
        start = 1'b1; wr_valid = 1'b1;
        @(negedge clk);
        start = 1'b0; idx_clr = 1'b0;
        clr_ok = (len == 0) ? 1'b1 : (!done && !fail && busy);
        cyc = 0;
        while (!(done || fail) && cyc < 5000) begin
            if (dev_vpp_req) saw_vpp = 1'b1;
            if (inj_at > 0 && cyc == inj_at) begin
                base_addr = AW'(10); length = (AW+1)'(1); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; wr_valid = 1'b0;
        if (cyc >= 5000) begin
            checks++; errors++;
            $display("FAIL run timeout at base %0d: actual %0d expected <5000", base, cyc);
        end
    endtask

    task automatic t_reset();
        chk("R1", "ce_n", dev_ce_n, 1);
        chk("R1", "oe_n", dev_oe_n, 1);
        chk("R1", "pgm_n", dev_pgm_n, 1);
        chk("R1", "vpp", dev_vpp_req, 0);
        chk("R1", "dq_oe", dev_dq_oe, 0);
        chk("R1", "busy/done/fail", {busy, done, fail}, 0);
    endtask

    task automatic t_basic();
        int cyc; bit sv, cl;
        model_clear();
        src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'h00; src[3] = 8'h7E;
        need[4] = 1; need[5] = 3; need[6] = 2; need[7] = MAXP;
        model_load();
        run(4, 4, 0, cyc, sv, cl);
        chk("R10", "basic done", done, 1);
        chk("R10", "basic fail", fail, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R10", "basic data", mem[4+i], src[i]);
            chk("R5", "basic pulses", got[4+i], need[4+i]);
        end
        chk("R8", "limit boundary byte passes", mem[7], 8'h7E);
        chk("R10", "below range untouched", mem[3], 8'hFF);
        chk("R10", "above range untouched", mem[8], 8'hFF);
        @(negedge clk);
        chk("R1", "idle after run", {busy, dev_vpp_req, dev_ce_n}, 3'b001);
    endtask

    task automatic t_skip();
        int cyc; bit sv, cl;
        model_clear();
        src[0] = 8'hFF; src[1] = 8'h5A; src[2] = 8'h0F;
        init_mem[21] = 8'h5A; need[22] = 2;
        model_load();
        run(20, 3, 0, cyc, sv, cl);
        chk("R6", "0xFF byte pulses", got[20], 0);
        chk("R6", "matching byte pulses", got[21], 0);
        chk("R5", "third byte pulses", got[22], 2);
        chk("R6", "skip run done", done, 1);
    endtask

    task automatic t_unprog();
        int cyc; bit sv, cl;
        model_clear();
        src[0] = 8'h11; src[1] = 8'hF0; src[2] = 8'h22;
        init_mem[31] = 8'h0F;
        model_load();
        run(30, 3, 0, cyc, sv, cl);
        chk("R7", "fail flag", fail, 1);
        chk("R7", "done flag", done, 0);
        chk("R7", "fail_addr", fail_addr, 31);
        chk("R7", "no pulse on bad byte", got[31], 0);
        chk("R7", "later byte untouched", mem[32], 8'hFF);
        chk("R7", "later byte pulses", got[32], 0);
        chk("R5", "first byte written", mem[30], 8'h11);
    endtask

    task automatic t_limit();
        int cyc; bit sv, cl;
        model_clear();
        src[0] = 8'h00; src[1] = 8'h00;
        need[40] = MAXP + 1;
        model_load();
        run(40, 2, 0, cyc, sv, cl);
        chk("R11", "status cleared on start", cl, 1);
        chk("R8", "fail flag", fail, 1);
        chk("R8", "fail_addr", fail_addr, 40);
        chk("R8", "pulses applied", got[40], MAXP);
        chk("R8", "cell unchanged", mem[40], 8'hFF);
        chk("R8", "next byte untouched", got[41], 0);
    endtask

    task automatic t_zero();
        int cyc; bit sv, cl;
        run(12, 0, 0, cyc, sv, cl);
        chk("R10", "zero length done", done, 1);
        chk("R10", "zero length no vpp", sv, 0);
        chk("R11", "zero length fail", fail, 0);
    endtask

    task automatic t_busy();
        int cyc; bit sv, cl;
        model_clear();
        src[0] = 8'h81; src[1] = 8'h42;
        need[50] = 3; need[51] = 3;
        model_load();
        run(50, 2, 20, cyc, sv, cl);
        chk("R11", "busy during run", cl, 1);
        chk("R11", "run done", done, 1);
        chk("R11", "data 0", mem[50], 8'h81);
        chk("R11", "data 1", mem[51], 8'h42);
        chk("R11", "ignored start address", got[10], 0);
        chk("R11", "ignored start cell", mem[10], 8'hFF);
    endtask

    task automatic t_monitors();
        chk("R3", "pulse width violations", bad_pw, 0);
        chk("R2", "settle violations", bad_settle, 0);
        chk("R4", "verify width violations", bad_oe, 0);
        chk("R4", "recovery violations", bad_rec, 0);
        chk("R4", "bus contention", bad_bus, 0);
        chk("R9", "address change without inhibit", bad_inh, 0);
        chk("R9", "voltage drop violations", bad_vpp, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        model_load();
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_skip();
        t_unprog();
        t_limit();
        t_zero();
        t_busy();
        t_monitors();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule